// File: doc/BRIEF.md
# Daisy-Chain Enumeration and Readback Sequencer

This block drives a chain of battery-monitor devices one frame at a time. A start command resets the chain and counts it. The block broadcasts two low-control writes and a read-pointer write, then reads frames until an all-zero word marks the end of the chain. Each device that answers must carry its own position in its address field. The chain length it finds is kept for the later commands.

With the chain known, a scan command broadcasts a conversion start. The block then waits for a delay that it computes from the acquisition-time setting, the averaging setting and the chain length. After the wait it reads twelve result frames for each device and adds up the cell-voltage results as they arrive. A channel command reads a single result from one device. It targets that device with the read pointer, silences readback on every other device, starts the conversion on the target, waits, and reads one frame.

The frame port is command level. The block hands out address, register, data and broadcast fields and takes back whole 32-bit frames along with a CRC verdict. A separate codec does the framing and the serial engine does the transfers. Any CRC or address fault ends the command and sets a status bit that stays set until the next command starts.

Top module: `chain_readback_seq`

## Requirements
- R1: After reset the block is idle. No request is offered, and `doneStb`, `errFlag` and `chainValid` are all low.
- R2: An enumerate command issues three writes, all broadcast (`reqAll`=1) to device field 0, in this order:
  - register 0x0E with data {1, acq[1:0], 10101b};
  - register 0x0E with data {0, acq[1:0], 10101b};
  - register 0x1C with data 0x38.
- R3: During enumeration the block reads frames with index 0 to MAX_DEVS. The first all-zero frame, at index n ≥ 1, ends the scan with `chainLast` = n−1 and `chainValid`=1. No further frame is read after it.
- R4: Enumeration fails, with `errFlag`=1 and `chainValid`=0, in any of these cases:
  - a zero frame at index 0;
  - a non-zero frame with CRC flagged bad;
  - a frame whose bits [31:27], read with their bit order reversed, differ from the frame index;
  - MAX_DEVS+1 frames read with none of them zero.
- R5: A scan command issues two broadcast writes to device field 0, in this order:
  - register 0x1C with data 0x00;
  - register 0x0D with data {0000b, 1, avg[1:0], 0}.
- R6: The wait runs from the accepted conversion-start write to the accepted first read. It is (ceil(T/1000)+5)·TICKS_PER_US+2 cycles, where T = (tA+695)·12·2^avg − tA + chainLast·250. tA is 465, 1010, 1460 or 1890 for acq = 0 to 3.
- R7: A scan reads (chainLast+1)·12 frames. `cellSum` becomes the sum of bits [22:11] over the frames whose channel field [26:23] is 5 or less.
- R8: A scan frame with a bad CRC sets `errFlag` and stops the reading at that frame.
- R9: A channel command for device d and channel c issues three writes, in this order:
  - device field rev(d), register 0x1C, data c<<2, `reqAll`=0;
  - device field 0, register 0x0D, data {0011b, 0, avg, 0}, `reqAll`=1;
  - device field rev(d), register 0x0D, data {0000b, 1, avg, 0}, `reqAll`=0.
  It then reads exactly one frame and places bits [22:11] of that frame on `chanValue`.
- R10: A channel read fails with `errFlag` set if the frame's CRC is bad, if bits [31:27] differ from rev(d), or if bits [26:23] differ from c.
- R11: `doneStb` pulses for one cycle when each command ends. `errFlag` stays set until the next command is accepted.
- R12: A scan or channel command given while `chainValid`=0 issues no frames, and raises `errFlag` and `doneStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startEnum | input | 1 | Start reset and enumeration (highest priority) |
| startScan | input | 1 | Start full conversion scan |
| startChan | input | 1 | Start single-channel read |
| chanDev | input | $clog2(MAX_DEVS) | Target device position for a channel read |
| chanSel | input | 4 | Target channel for a channel read |
| acqSel | input | 2 | Acquisition-time setting |
| avgSel | input | 2 | Averaging setting (2^avgSel samples) |
| reqValid | output | 1 | Frame request offered |
| reqReady | input | 1 | Frame request accepted |
| reqWrite | output | 1 | 1 = register write, 0 = readback slot |
| reqDev | output | 5 | Device address field as sent |
| reqReg | output | 6 | Register address |
| reqData | output | 8 | Register data |
| reqAll | output | 1 | Broadcast to all devices |
| rspValid | input | 1 | Readback frame present |
| rspFrame | input | 32 | Readback frame |
| rspCrcOk | input | 1 | CRC verdict for rspFrame |
| busy | output | 1 | Command in progress |
| doneStb | output | 1 | Command finished (one cycle) |
| errFlag | output | 1 | Sticky fault of the last command |
| chainValid | output | 1 | Enumeration succeeded |
| chainLast | output | $clog2(MAX_DEVS) | Index of the last device in the chain |
| cellSum | output | 12+$clog2(6·MAX_DEVS+1) | Sum of the cell results from the last scan |
| chanValue | output | 12 | Result of the last channel read |

## Verification
The bench builds the block with MAX_DEVS=8 and TICKS_PER_US=3. Every chain length from one to eight devices is enumerated. With three ticks per microsecond, even the longest wait (acquisition setting 3, averaging 8, full chain) lasts under a thousand cycles. That makes it affordable to sweep all sixteen acquisition and averaging pairs, and to check each wait to the exact cycle against the arithmetic formula. The fault cases are each injected at a chosen frame index: zero first frame, bad CRC, wrong address, missing terminator, bad scan CRC, and mismatched channel.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  localparam logic [5:0] REG_CTRL_HI = 6'h0D;
  localparam logic [5:0] REG_CTRL_LO = 6'h0E;
  localparam logic [5:0] REG_RDPTR   = 6'h1C;
  localparam logic [4:0] DEV_FILLER  = 5'h1F;

  typedef enum logic [1:0] {MODE_ENUM, MODE_SCAN, MODE_CHAN} modeT;

  typedef struct packed {
    logic dropChain;
    logic clrIdx;
    logic incIdx;
    logic ldWait;
    logic clrSum;
    logic accFrame;
    logic latchLast;
    logic latchChan;
  } strobeT;

  typedef struct packed {
    logic waitDone;
    logic frameZero;
    logic idxZero;
    logic crcBad;
    logic enumAddrBad;
    logic enumAtMax;
    logic scanLast;
    logic chanBad;
  } statT;

  // device address field travels with its bit order reversed
  function automatic logic [4:0] bitRev5(input logic [4:0] v);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = v[4-i];
    return r;
  endfunction

endpackage

// File: rtl/cseq_dpath.sv
module cseq_dpath import cseq_pkg::*; #(
  parameter int MAX_DEVS     = 8,
  parameter int TICKS_PER_US = 50,
  parameter int TAIL_US      = 5,
  parameter int DEV_W        = $clog2(MAX_DEVS),
  parameter int SUM_W        = 12 + $clog2(MAX_DEVS * 6 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [1:0]       cfgAcq,
  input  logic [1:0]       cfgAvg,
  input  logic [4:0]       tgtDev,
  input  logic [3:0]       tgtChan,
  input  logic [31:0]      rspFrame,
  input  logic             rspCrcOk,
  output statT             stat,
  output logic             chainValid,
  output logic [DEV_W-1:0] chainLast,
  output logic [SUM_W-1:0] cellSum,
  output logic [11:0]      chanValue
);

  localparam int IDX_W  = $clog2(MAX_DEVS * 12 + 1);
  localparam int NS_W   = $clog2(2585 * 12 * 8 + MAX_DEVS * 250 + 1);
  localparam int PRE_W  = $clog2(TICKS_PER_US + 1);
  localparam int TAIL_W = $clog2(TAIL_US + 1);

  logic [IDX_W-1:0]  idx;
  logic [NS_W-1:0]   nsLeft, tAcq, waitNs;
  logic [PRE_W-1:0]  pre;
  logic [TAIL_W-1:0] tailCnt;
  logic              mainPh;

  logic [4:0]  fDev;
  logic [3:0]  fChan;
  logic [11:0] fVal;
  assign fDev  = rspFrame[31:27];
  assign fChan = rspFrame[26:23];
  assign fVal  = rspFrame[22:11];

  always_comb begin
    case (cfgAcq)
      2'd0:    tAcq = NS_W'(465);
      2'd1:    tAcq = NS_W'(1010);
      2'd2:    tAcq = NS_W'(1460);
      default: tAcq = NS_W'(1890);
    endcase
    waitNs = (((tAcq + NS_W'(695)) * NS_W'(12)) << cfgAvg) - tAcq
             + NS_W'(chainLast) * NS_W'(250);
  end

  logic [IDX_W-1:0] scanEnd;
  assign scanEnd = IDX_W'(chainLast) * IDX_W'(12) + IDX_W'(11);

  always_comb begin
    stat.waitDone    = !mainPh && (tailCnt == '0);
    stat.frameZero   = (rspFrame == 32'd0);
    stat.idxZero     = (idx == '0);
    stat.crcBad      = !rspCrcOk;
    stat.enumAddrBad = (IDX_W'(bitRev5(fDev)) != idx);
    stat.enumAtMax   = (idx == IDX_W'(MAX_DEVS));
    stat.scanLast    = (idx == scanEnd);
    stat.chanBad     = (fDev != tgtDev) || (fChan != tgtChan);
  end

  // wait timer: whole microseconds covering T, then a fixed tail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nsLeft  <= '0;
      pre     <= '0;
      tailCnt <= '0;
      mainPh  <= 1'b0;
    end else if (stb.ldWait) begin
      nsLeft  <= waitNs;
      pre     <= PRE_W'(TICKS_PER_US - 1);
      tailCnt <= TAIL_W'(TAIL_US);
      mainPh  <= 1'b1;
    end else if (mainPh || tailCnt != '0) begin
      if (pre == '0) begin
        pre <= PRE_W'(TICKS_PER_US - 1);
        if (mainPh) begin
          if (nsLeft > NS_W'(1000)) nsLeft <= nsLeft - NS_W'(1000);
          else                      mainPh <= 1'b0;
        end else begin
          tailCnt <= tailCnt - TAIL_W'(1);
        end
      end else begin
        pre <= pre - PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx        <= '0;
      chainValid <= 1'b0;
      chainLast  <= '0;
      cellSum    <= '0;
      chanValue  <= '0;
    end else begin
      if (stb.clrIdx)      idx <= '0;
      else if (stb.incIdx) idx <= idx + IDX_W'(1);
      if (stb.dropChain)   chainValid <= 1'b0;
      if (stb.latchLast) begin
        chainValid <= 1'b1;
        chainLast  <= DEV_W'(idx - IDX_W'(1));
      end
      if (stb.clrSum)      cellSum <= '0;
      else if (stb.accFrame && fChan <= 4'd5)
        cellSum <= cellSum + SUM_W'(fVal);
      if (stb.latchChan)   chanValue <= fVal;
    end
  end

endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl import cseq_pkg::*; #(
  parameter int DEV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEnum,
  input  logic             startScan,
  input  logic             startChan,
  input  logic [DEV_W-1:0] chanDev,
  input  logic [3:0]       chanSel,
  input  logic [1:0]       acqSel,
  input  logic [1:0]       avgSel,
  input  logic             chainValid,
  input  statT             stat,
  input  logic             reqReady,
  input  logic             rspValid,
  output logic             reqValid,
  output logic             reqWrite,
  output logic [4:0]       reqDev,
  output logic [5:0]       reqReg,
  output logic [7:0]       reqData,
  output logic             reqAll,
  output logic             busy,
  output logic             doneStb,
  output logic             errFlag,
  output strobeT           stb,
  output logic [4:0]       tgtDev,
  output logic [3:0]       tgtChan,
  output logic [1:0]       cfgAcq,
  output logic [1:0]       cfgAvg
);

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_WAIT, ST_RDREQ, ST_RDRSP} stateT;

  stateT      state;
  modeT       mode;
  logic [1:0] step, lastStep;
  logic       anyStart, finish, fail, advance;

  assign anyStart = startEnum || startScan || startChan;
  assign lastStep = (mode == MODE_SCAN) ? 2'd1 : 2'd2;
  assign busy     = (state != ST_IDLE);

  // frame command fields
  always_comb begin
    reqValid = (state == ST_CMD) || (state == ST_RDREQ);
    reqWrite = (state == ST_CMD);
    reqDev   = DEV_FILLER;
    reqReg   = 6'h00;
    reqData  = 8'h00;
    reqAll   = 1'b0;
    if (state == ST_CMD) begin
      reqDev = 5'd0;
      reqAll = 1'b1;
      case (mode)
        MODE_ENUM: begin
          reqReg  = (step == 2'd2) ? REG_RDPTR : REG_CTRL_LO;
          reqData = (step == 2'd2) ? {REG_CTRL_LO, 2'b00}
                                   : {(step == 2'd0), cfgAcq, 5'b10101};
        end
        MODE_SCAN: begin
          reqReg  = (step == 2'd0) ? REG_RDPTR : REG_CTRL_HI;
          reqData = (step == 2'd0) ? 8'h00 : {4'b0000, 1'b1, cfgAvg, 1'b0};
        end
        default: begin
          case (step)
            2'd0: begin
              reqDev = tgtDev; reqAll = 1'b0; reqReg = REG_RDPTR;
              reqData = {2'b00, tgtChan, 2'b00};
            end
            2'd1: begin
              reqReg = REG_CTRL_HI; reqData = {4'b0011, 1'b0, cfgAvg, 1'b0};
            end
            default: begin
              reqDev = tgtDev; reqAll = 1'b0; reqReg = REG_CTRL_HI;
              reqData = {4'b0000, 1'b1, cfgAvg, 1'b0};
            end
          endcase
        end
      endcase
    end
  end

  // strobes toward the datapath and end-of-command decisions
  always_comb begin
    stb     = '0;
    finish  = 1'b0;
    fail    = 1'b0;
    advance = 1'b0;
    case (state)
      ST_IDLE: stb.dropChain = startEnum;
      ST_CMD: if (reqReady && step == lastStep) begin
        stb.clrIdx = 1'b1;
        if (mode != MODE_ENUM) begin
          stb.ldWait = 1'b1;
          stb.clrSum = 1'b1;
        end
      end
      ST_RDRSP: if (rspValid) begin
        case (mode)
          MODE_ENUM: begin
            if (stat.frameZero) begin
              if (stat.idxZero) fail = 1'b1;
              else begin stb.latchLast = 1'b1; finish = 1'b1; end
            end else if (stat.crcBad || stat.enumAddrBad || stat.enumAtMax) begin
              fail = 1'b1;
            end else begin
              stb.incIdx = 1'b1; advance = 1'b1;
            end
          end
          MODE_SCAN: begin
            if (stat.crcBad) fail = 1'b1;
            else begin
              stb.accFrame = 1'b1;
              if (stat.scanLast) finish = 1'b1;
              else begin stb.incIdx = 1'b1; advance = 1'b1; end
            end
          end
          default: begin
            if (stat.crcBad || stat.chanBad) fail = 1'b1;
            else begin stb.latchChan = 1'b1; finish = 1'b1; end
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      mode    <= MODE_ENUM;
      step    <= 2'd0;
      doneStb <= 1'b0;
      errFlag <= 1'b0;
      tgtDev  <= 5'd0;
      tgtChan <= 4'd0;
      cfgAcq  <= 2'd0;
      cfgAvg  <= 2'd0;
    end else begin
      doneStb <= 1'b0;
      case (state)
        ST_IDLE: if (anyStart) begin
          errFlag <= 1'b0;
          cfgAcq  <= acqSel;
          cfgAvg  <= avgSel;
          tgtDev  <= bitRev5(5'(chanDev));
          tgtChan <= chanSel;
          step    <= 2'd0;
          if (startEnum) begin
            mode  <= MODE_ENUM;
            state <= ST_CMD;
          end else if (!chainValid) begin
            errFlag <= 1'b1;
            doneStb <= 1'b1;
          end else begin
            mode  <= startScan ? MODE_SCAN : MODE_CHAN;
            state <= ST_CMD;
          end
        end
        ST_CMD: if (reqReady) begin
          if (step == lastStep) state <= (mode == MODE_ENUM) ? ST_RDREQ : ST_WAIT;
          else                  step  <= step + 2'd1;
        end
        ST_WAIT:  if (stat.waitDone) state <= ST_RDREQ;
        ST_RDREQ: if (reqReady) state <= ST_RDRSP;
        ST_RDRSP: begin
          if (fail || finish) begin
            state   <= ST_IDLE;
            doneStb <= 1'b1;
            errFlag <= fail;
          end else if (advance) begin
            state <= ST_RDREQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chain_readback_seq.sv
module chain_readback_seq import cseq_pkg::*; #(
  parameter int MAX_DEVS     = 8,
  parameter int TICKS_PER_US = 50,
  parameter int TAIL_US      = 5,
  localparam int DEV_W       = $clog2(MAX_DEVS),
  localparam int SUM_W       = 12 + $clog2(MAX_DEVS * 6 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEnum,
  input  logic             startScan,
  input  logic             startChan,
  input  logic [DEV_W-1:0] chanDev,
  input  logic [3:0]       chanSel,
  input  logic [1:0]       acqSel,
  input  logic [1:0]       avgSel,
  output logic             reqValid,
  input  logic             reqReady,
  output logic             reqWrite,
  output logic [4:0]       reqDev,
  output logic [5:0]       reqReg,
  output logic [7:0]       reqData,
  output logic             reqAll,
  input  logic             rspValid,
  input  logic [31:0]      rspFrame,
  input  logic             rspCrcOk,
  output logic             busy,
  output logic             doneStb,
  output logic             errFlag,
  output logic             chainValid,
  output logic [DEV_W-1:0] chainLast,
  output logic [SUM_W-1:0] cellSum,
  output logic [11:0]      chanValue
);

  strobeT     stb;
  statT       stat;
  logic [4:0] tgtDev;
  logic [3:0] tgtChan;
  logic [1:0] cfgAcq, cfgAvg;

  cseq_ctrl #(.DEV_W(DEV_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startEnum(startEnum), .startScan(startScan), .startChan(startChan),
    .chanDev(chanDev), .chanSel(chanSel), .acqSel(acqSel), .avgSel(avgSel),
    .chainValid(chainValid), .stat(stat),
    .reqReady(reqReady), .rspValid(rspValid),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqDev(reqDev), .reqReg(reqReg),
    .reqData(reqData), .reqAll(reqAll),
    .busy(busy), .doneStb(doneStb), .errFlag(errFlag),
    .stb(stb), .tgtDev(tgtDev), .tgtChan(tgtChan), .cfgAcq(cfgAcq), .cfgAvg(cfgAvg)
  );

  cseq_dpath #(
    .MAX_DEVS(MAX_DEVS), .TICKS_PER_US(TICKS_PER_US), .TAIL_US(TAIL_US),
    .DEV_W(DEV_W), .SUM_W(SUM_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgAcq(cfgAcq), .cfgAvg(cfgAvg), .tgtDev(tgtDev), .tgtChan(tgtChan),
    .rspFrame(rspFrame), .rspCrcOk(rspCrcOk), .stat(stat),
    .chainValid(chainValid), .chainLast(chainLast),
    .cellSum(cellSum), .chanValue(chanValue)
  );

endmodule

// File: rtl/cseq_checks.sv
module cseq_checks #(
  parameter int SUM_W = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             startEnum,
  input logic             startScan,
  input logic             startChan,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqWrite,
  input logic [4:0]       reqDev,
  input logic [5:0]       reqReg,
  input logic [7:0]       reqData,
  input logic             reqAll,
  input logic             busy,
  input logic             doneStb,
  input logic             errFlag,
  input logic [SUM_W-1:0] cellSum
);

  // a request that is not taken keeps its fields (R2, R5, R9)
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable({reqWrite, reqDev, reqReg, reqData, reqAll}));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> !busy);

  p_end_signals_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneStb);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !(!busy && (startEnum || startScan || startChan)) |=> errFlag);

  p_sum_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy && $past(!busy) |-> $stable(cellSum));

endmodule

bind chain_readback_seq cseq_checks #(.SUM_W(SUM_W)) u_checks (
  .clk(clk), .rstN(rstN),
  .startEnum(startEnum), .startScan(startScan), .startChan(startChan),
  .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
  .reqDev(reqDev), .reqReg(reqReg), .reqData(reqData), .reqAll(reqAll),
  .busy(busy), .doneStb(doneStb), .errFlag(errFlag), .cellSum(cellSum)
);

// File: tb/chain_readback_seq_tb.sv
module chain_readback_seq_tb;

  localparam int MAXD = 8;
  localparam int TPU  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startEnum = 1'b0, startScan = 1'b0, startChan = 1'b0;
  logic [2:0]  chanDev = '0;
  logic [3:0]  chanSel = '0;
  logic [1:0]  acqSel = '0, avgSel = '0;
  logic        reqReady = 1'b1;
  logic        reqValid, reqWrite, reqAll;
  logic [4:0]  reqDev;
  logic [5:0]  reqReg;
  logic [7:0]  reqData;
  logic        rspValid = 1'b0;
  logic [31:0] rspFrame = '0;
  logic        rspCrcOk = 1'b0;
  logic        busy, doneStb, errFlag, chainValid;
  logic [2:0]  chainLast;
  logic [17:0] cellSum;
  logic [11:0] chanValue;

  int total = 0, bad = 0;
  int cyc = 0, rdCnt = 0, rBase = 0, wCnt = 0, wBase = 0;
  int lastWrCyc = 0, firstRdCyc = 0;
  logic [31:0] frames [0:127];
  logic        crcOk  [0:127];
  logic [19:0] wLog   [0:255];

  always #10 clk = ~clk;

  chain_readback_seq #(.MAX_DEVS(MAXD), .TICKS_PER_US(TPU)) u_dut (
    .clk(clk), .rstN(rstN), .startEnum(startEnum), .startScan(startScan),
    .startChan(startChan), .chanDev(chanDev), .chanSel(chanSel),
    .acqSel(acqSel), .avgSel(avgSel), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqDev(reqDev), .reqReg(reqReg), .reqData(reqData),
    .reqAll(reqAll), .rspValid(rspValid), .rspFrame(rspFrame), .rspCrcOk(rspCrcOk),
    .busy(busy), .doneStb(doneStb), .errFlag(errFlag), .chainValid(chainValid),
    .chainLast(chainLast), .cellSum(cellSum), .chanValue(chanValue)
  );

  // chain model: logs writes, answers each read slot the next cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rspValid <= 1'b0;
    if (rstN && reqValid && reqReady) begin
      if (reqWrite) begin
        wLog[wCnt & 255] <= {reqDev, reqReg, reqData, reqAll};
        wCnt <= wCnt + 1;
        lastWrCyc <= cyc;
      end else begin
        rspValid <= 1'b1;
        rspFrame <= frames[(rdCnt - rBase) & 127];
        rspCrcOk <= crcOk[(rdCnt - rBase) & 127];
        if (rdCnt == rBase) firstRdCyc <= cyc;
        rdCnt <= rdCnt + 1;
      end
    end
  end

  function automatic logic [4:0] rev5(input int v);
    logic [4:0] a, r;
    a = 5'(v);
    for (int i = 0; i < 5; i++) r[i] = a[4-i];
    return r;
  endfunction

  function automatic int expGap(input int acq, input int avg, input int last);
    int ta, t, k;
    ta = (acq == 0) ? 465 : (acq == 1) ? 1010 : (acq == 2) ? 1460 : 1890;
    t  = (ta + 695) * 12 * (1 << avg) - ta + last * 250;
    k  = (t + 999) / 1000;
    return (k + 5) * TPU + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chkWr(input int i, input logic [4:0] d, input logic [5:0] r,
                       input logic [7:0] v, input logic a, input string tag);
    logic [19:0] e;
    e = {d, r, v, a};
    chk(wLog[(wBase + i) & 255] == e, tag, wLog[(wBase + i) & 255], e);
  endtask

  task automatic runCmd(input int kind);
    int n = 0;
    wBase = wCnt;
    rBase = rdCnt;
    @(negedge clk);
    startEnum = (kind == 0); startScan = (kind == 1); startChan = (kind == 2);
    @(negedge clk);
    startEnum = 0; startScan = 0; startChan = 0;
    while (!doneStb && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R11 done seen", n, 0);
  endtask

  task automatic fillEnum(input int n);
    for (int i = 0; i < 128; i++) begin
      frames[i] = (i < n) ? {rev5(i), 27'(i * 1234 + 77)} : 32'd0;
      crcOk[i]  = 1'b1;
    end
  endtask

  task automatic doEnum(input int n);
    fillEnum(n);
    acqSel = 2'(n);
    runCmd(0);
    chkWr(0, 5'd0, 6'h0E, {1'b1, 2'(n), 5'b10101}, 1'b1, "R2 first write");
    chkWr(1, 5'd0, 6'h0E, {1'b0, 2'(n), 5'b10101}, 1'b1, "R2 second write");
    chkWr(2, 5'd0, 6'h1C, 8'h38, 1'b1, "R2 third write");
    chk(chainValid && !errFlag, "R3 enum ok", {chainValid, errFlag}, 2);
    chk(chainLast == 3'(n - 1), "R3 chain last", chainLast, n - 1);
    chk(rdCnt - rBase == n + 1, "R3 frames read", rdCnt - rBase, n + 1);
  endtask

  task automatic doScan(input int acq, input int avg, input int nDev);
    int exp = 0;
    for (int f = 0; f < 128; f++) begin
      int v = (f * 173 + acq * 29 + avg * 7 + 5) & 12'hFFF;
      frames[f] = {rev5(f / 12), 4'(f % 12), 12'(v), 11'd0};
      crcOk[f]  = 1'b1;
      if (f < nDev * 12 && (f % 12) <= 5) exp += v;
    end
    acqSel = 2'(acq); avgSel = 2'(avg);
    runCmd(1);
    chkWr(0, 5'd0, 6'h1C, 8'h00, 1'b1, "R5 read pointer write");
    chkWr(1, 5'd0, 6'h0D, {4'b0000, 1'b1, 2'(avg), 1'b0}, 1'b1, "R5 convert write");
    chk(firstRdCyc - lastWrCyc == expGap(acq, avg, nDev - 1), "R6 scan wait",
        firstRdCyc - lastWrCyc, expGap(acq, avg, nDev - 1));
    chk(rdCnt - rBase == nDev * 12, "R7 frame count", rdCnt - rBase, nDev * 12);
    chk(int'(cellSum) == exp, "R7 cell sum", cellSum, exp);
    chk(!errFlag, "R7 no error", errFlag, 0);
  endtask

  task automatic doChan(input int dev, input int ch, input int mode);
    for (int i = 0; i < 128; i++) begin frames[i] = '0; crcOk[i] = 1'b1; end
    frames[0] = {rev5(dev), 4'(ch), 12'(dev * 300 + ch * 11 + 1), 11'd0};
    if (mode == 1) frames[0][26:23] = 4'(ch + 1);
    if (mode == 2) crcOk[0] = 1'b0;
    if (mode == 3) frames[0][31:27] = rev5(dev + 1);
    chanDev = 3'(dev); chanSel = 4'(ch); acqSel = 2'd1; avgSel = 2'd2;
    runCmd(2);
    if (mode == 0) begin
      chkWr(0, rev5(dev), 6'h1C, {2'b00, 4'(ch), 2'b00}, 1'b0, "R9 pointer write");
      chkWr(1, 5'd0, 6'h0D, 8'h34, 1'b1, "R9 silence write");
      chkWr(2, rev5(dev), 6'h0D, 8'h0C, 1'b0, "R9 target convert write");
      chk(rdCnt - rBase == 1, "R9 one frame", rdCnt - rBase, 1);
      chk(chanValue == 12'(dev * 300 + ch * 11 + 1), "R9 value", chanValue, dev * 300 + ch * 11 + 1);
      chk(!errFlag, "R9 no error", errFlag, 0);
      chk(firstRdCyc - lastWrCyc == expGap(1, 2, MAXD - 1), "R6 chan wait",
          firstRdCyc - lastWrCyc, expGap(1, 2, MAXD - 1));
    end else begin
      chk(errFlag, "R10 channel fault", errFlag, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !reqValid && !doneStb && !errFlag && !chainValid, "R1 reset state",
        {busy, reqValid, doneStb, errFlag, chainValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !reqValid, "R1 idle after release", {busy, reqValid}, 0);

    // R12: scan before any chain exists
    runCmd(1);
    chk(errFlag && wCnt == wBase && rdCnt == rBase, "R12 scan without chain",
        {errFlag, 1'(wCnt != wBase)}, 2);

    for (int n = 1; n <= MAXD; n++) doEnum(n);

    // R4 failures
    fillEnum(0);
    runCmd(0);
    chk(errFlag && !chainValid, "R4 zero at index 0", {errFlag, chainValid}, 2);
    runCmd(2);
    chk(errFlag && rdCnt == rBase, "R12 channel without chain", errFlag, 1);
    fillEnum(4); crcOk[2] = 1'b0;
    runCmd(0);
    chk(errFlag && !chainValid && rdCnt - rBase == 3, "R4 crc fault", rdCnt - rBase, 3);
    fillEnum(4); frames[1][31:27] = rev5(3);
    runCmd(0);
    chk(errFlag && !chainValid && rdCnt - rBase == 2, "R4 address fault", rdCnt - rBase, 2);
    fillEnum(MAXD + 1);
    runCmd(0);
    chk(errFlag && !chainValid && rdCnt - rBase == MAXD + 1, "R4 no terminator",
        rdCnt - rBase, MAXD + 1);

    // R11: error clears on next accepted command
    doEnum(2);
    chk(!errFlag, "R11 error cleared", errFlag, 0);
    for (int a = 0; a < 4; a++)
      for (int v = 0; v < 4; v++) doScan(a, v, 2);

    // R8: crc fault mid-scan
    for (int f = 0; f < 128; f++) begin frames[f] = {5'd0, 4'(f % 12), 12'd1, 11'd0}; crcOk[f] = 1'b1; end
    crcOk[5] = 1'b0;
    runCmd(1);
    chk(errFlag && rdCnt - rBase == 6, "R8 scan crc stop", rdCnt - rBase, 6);

    doEnum(MAXD);
    doScan(3, 3, MAXD);
    doScan(0, 0, MAXD);
    doScan(2, 1, MAXD);

    doChan(5, 7, 0);
    doChan(0, 2, 0);
    doChan(7, 11, 0);
    doChan(3, 4, 1);
    doChan(3, 4, 2);
    doChan(6, 1, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule